// File: doc/BRIEF.md
# Periodic Interval Timer

A register-mapped timer for building a system tick and a monotonic time base. A fixed divide-by-16 prescaler turns the clock into ticks. A 20-bit interval counter advances on each tick and returns to zero after reaching a programmed period. Each return to zero sets a status flag and adds one to a 12-bit count of periods that software has not yet acknowledged.

Software reads the live counter and the period count together from one 32-bit word. It can read that word from two offsets. A read at the acknowledge offset clears the flag and the period count. A read at the snapshot offset has no side effect. A level interrupt is raised while the flag is set and both enables are on. When the counter is disabled, it runs to the end of the current interval and stops at zero.

Top module: `pit_timer`

## Requirements
- R1: After reset, every register reads zero, irq_o is low, and the interval counter stays at zero.
- R2: While running, the interval count in rdata bits 19:0 advances by one every 16 clock cycles.
- R3: With period P in mode bits 19:0, the interval count runs 0..P and then returns to zero. Each return sets status bit 0 (offset 0x4) and adds one to the period count in bits 31:20.
- R4: Offsets 0x8 and 0xC both return {period count[31:20], interval count[19:0]}.
- R5: A read at 0x8 returns the flag and count as they were before the read, then clears both.
- R6: A read at 0xC returns the same word as 0x8 and changes nothing.
- R7: irq_o is high exactly when the enable (mode bit 24), the interrupt enable (mode bit 25) and the status flag are all set.
- R8: When the enable bit is cleared, the counter keeps counting until it reaches zero and then holds there, with the prescaler cleared.
- R9: If never acknowledged, the period count wraps from 4095 to 0.
- R10: If a return to zero and a read at 0x8 fall in the same cycle, the flag ends set and the period count ends at one.
- R11: Writes at 0x4, 0x8 and 0xC are ignored. Offset 0x0 reads back the period field (bits 19:0), the enable (bit 24) and the interrupt enable (bit 25).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access in this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset into the 16-byte window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as a read |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that every access lasts one cycle with the address word aligned, and that bus inputs change only away from the rising edge. The bench drives every input at the falling edge and holds it for a whole cycle. It uses only aligned offsets and single-cycle reads, so each acknowledge read is seen exactly once. It reads at the acknowledge offset on every cycle of a short-period stretch, so that a read lands on the same cycle as a return to zero.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned PRE_W   = 4;
  localparam int unsigned CNT_W   = 20;
  localparam int unsigned PIC_W   = 12;
  localparam int unsigned EN_BIT  = 24;
  localparam int unsigned IEN_BIT = 25;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_STAT  = 2'd1,
    REG_VALUE = 2'd2,
    REG_IMAGE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned PRE_W = pit_pkg::PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] presc_o
);
  logic [PRE_W-1:0] presc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    presc_q <= '0;
    else if (run_i) presc_q <= presc_q + 1'b1;
    else            presc_q <= '0;
  end

  assign tick_o  = run_i && (&presc_q);
  assign presc_o = presc_q;
endmodule

// File: rtl/pit_interval_counter.sv
module pit_interval_counter #(
  parameter int unsigned CNT_W = pit_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q;

  // keeps running after disable until the interval ends at zero
  assign active_o = en_i || (|cnt_q);
  // >= so that lowering the period below the live count still wraps
  assign wrap_o   = tick_i && (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pit_period_tracker.sv
module pit_period_tracker #(
  parameter int unsigned PIC_W = pit_pkg::PIC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             ack_i,
  output logic             flag_o,
  output logic [PIC_W-1:0] pic_o
);
  logic             flag_q;
  logic [PIC_W-1:0] pic_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      pic_q  <= '0;
    end else if (ack_i) begin
      // a wrap in the ack cycle counts as the first new period
      flag_q <= wrap_i;
      pic_q  <= wrap_i ? PIC_W'(1) : '0;
    end else if (wrap_i) begin
      flag_q <= 1'b1;
      pic_q  <= pic_q + 1'b1;
    end
  end

  assign flag_o = flag_q;
  assign pic_o  = pic_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned PRE_BITS = PRE_W,
  parameter int unsigned CNT_BITS = CNT_W,
  parameter int unsigned PIC_BITS = PIC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  reg_sel_e            reg_sel;
  logic                rd_req, wr_mode, ack;
  logic                en_q, ien_q;
  logic [CNT_BITS-1:0] period_q;
  logic [CNT_BITS-1:0] cnt;
  logic [PIC_BITS-1:0] pic;
  logic [PRE_BITS-1:0] presc;
  logic                flag, tick, wrap, active;
  logic                unused_bits;

  assign reg_sel = reg_sel_e'(addr_i[3:2]);
  assign rd_req  = sel_i && !wr_i;
  assign wr_mode = sel_i && wr_i && (reg_sel == REG_MODE);
  assign ack     = rd_req && (reg_sel == REG_VALUE);
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:IEN_BIT+1],
                         wdata_i[EN_BIT-1:CNT_BITS]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      ien_q    <= 1'b0;
      period_q <= '0;
    end else if (wr_mode) begin
      en_q     <= wdata_i[EN_BIT];
      ien_q    <= wdata_i[IEN_BIT];
      period_q <= wdata_i[CNT_BITS-1:0];
    end
  end

  pit_prescaler #(.PRE_W(PRE_BITS)) i_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(active),
    .tick_o(tick), .presc_o(presc)
  );

  pit_interval_counter #(.CNT_W(CNT_BITS)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .tick_i(tick),
    .period_i(period_q), .cnt_o(cnt), .wrap_o(wrap), .active_o(active)
  );

  pit_period_tracker #(.PIC_W(PIC_BITS)) i_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .ack_i(ack),
    .flag_o(flag), .pic_o(pic)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_req) begin
      unique case (reg_sel)
        REG_MODE: begin
          rdata_o[CNT_BITS-1:0] = period_q;
          rdata_o[EN_BIT]       = en_q;
          rdata_o[IEN_BIT]      = ien_q;
        end
        REG_STAT:  rdata_o[0] = flag;
        default:   rdata_o = {pic, cnt};
      endcase
    end
  end

  assign irq_o = en_q && ien_q && flag;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int unsigned PRE_BITS = pit_pkg::PRE_W,
  parameter int unsigned CNT_BITS = pit_pkg::CNT_W,
  parameter int unsigned PIC_BITS = pit_pkg::PIC_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sel_i,
  input logic                wr_i,
  input logic [3:0]          addr_i,
  input logic                irq_o,
  input logic                en_q,
  input logic                ien_q,
  input logic [CNT_BITS-1:0] period_q,
  input logic [CNT_BITS-1:0] cnt,
  input logic [PIC_BITS-1:0] pic,
  input logic [PRE_BITS-1:0] presc,
  input logic                flag,
  input logic                wrap
);
  logic ack_w;
  assign ack_w = sel_i && !wr_i && (addr_i[3:2] == 2'd2);

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt) |-> ($past(presc) == {PRE_BITS{1'b1}}));

  // R3
  wrap_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !ack_w) |=> (flag && cnt == '0));

  // R5
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && !wrap) |=> (!flag && pic == '0 && !irq_o));

  // R7
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q && ien_q));

  // R8
  stop_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && cnt == '0) |=> (cnt == '0 && presc == '0));

  // R9
  pic_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !ack_w && pic == {PIC_BITS{1'b1}}) |=> (pic == '0));

  // R10
  ack_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && wrap) |=> (flag && pic == PIC_BITS'(1)));

  // R11
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i[3:2] != 2'd0) |=>
      ($stable(en_q) && $stable(ien_q) && $stable(period_q)));
endmodule

bind pit_timer pit_timer_chk #(
  .PRE_BITS(PRE_BITS), .CNT_BITS(CNT_BITS), .PIC_BITS(PIC_BITS)
) i_pit_timer_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i),
  .addr_i(addr_i), .irq_o(irq_o), .en_q(en_q), .ien_q(ien_q),
  .period_q(period_q), .cnt(cnt), .pic(pic), .presc(presc),
  .flag(flag), .wrap(wrap)
);

// File: tb/test_pit_timer.sv
module test_pit_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_pre, m_cnt, m_pic, m_flag, m_piv, m_en, m_ien;

  pit_timer i_pit_timer (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_pic = 0; m_flag = 0; m_piv = 0; m_en = 0; m_ien = 0;
    end else begin
      automatic bit active = (m_en != 0) || (m_cnt != 0);
      automatic bit tick   = active && (m_pre == 15);
      automatic bit wrp    = tick && (m_cnt >= m_piv);
      automatic bit ackr   = sel && !wr && (addr == 4'h8);
      if (tick) m_cnt = wrp ? 0 : m_cnt + 1;
      m_pre = active ? (m_pre + 1) % 16 : 0;
      if (ackr) begin
        m_flag = wrp ? 1 : 0;
        m_pic  = wrp ? 1 : 0;
      end else if (wrp) begin
        m_flag = 1;
        m_pic  = (m_pic + 1) % 4096;
      end
      if (sel && wr && addr == 4'h0) begin
        m_piv = int'(wdata[19:0]);
        m_en  = int'(wdata[24]);
        m_ien = int'(wdata[25]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WDOG_LIMIT) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<%0d", cycles, WDOG_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] exp_rdata();
    logic [31:0] e = '0;
    if (sel && !wr) begin
      case (addr)
        4'h0: begin e[19:0] = m_piv[19:0]; e[24] = m_en[0]; e[25] = m_ien[0]; end
        4'h4: e[0] = m_flag[0];
        default: e = {m_pic[11:0], m_cnt[19:0]};
      endcase
    end
    return e;
  endfunction

  task automatic compare();
    logic [31:0] e = exp_rdata();
    logic ei = (m_en != 0) && (m_ien != 0) && (m_flag != 0);
    checks += 2;
    if (rdata !== e) begin
      failures++;
      $display("FAIL %s rdata addr=%h act=%h exp=%h", cur_req, addr, rdata, e);
    end
    if (irq !== ei) begin
      failures++;
      $display("FAIL %s irq act=%b exp=%b", cur_req, irq, ei);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [3:0] a,
                     input logic [31:0] d);
    @(negedge clk);
    compare();
    sel = s; wr = w; addr = a; wdata = d;
  endtask

  task automatic run(input int n, input logic s, input logic w,
                     input logic [3:0] a, input logic [31:0] d);
    for (int i = 0; i < n; i++) cyc(s, w, a, d);
  endtask

  initial begin
    // R1: reset state across all offsets
    cur_req = "R1";
    run(2, 1, 0, 4'hC, 0);
    rst_n = 1'b1;
    run(5, 1, 0, 4'hC, 0);
    run(2, 1, 0, 4'h0, 0);
    run(2, 1, 0, 4'h4, 0);
    run(2, 1, 0, 4'h8, 0);

    // R2 / R3 / R4: period 3, irq disabled
    cur_req = "R2";
    cyc(1, 1, 4'h0, 32'h0100_0003);
    run(40, 1, 0, 4'hC, 0);
    cur_req = "R3";
    run(200, 1, 0, 4'hC, 0);
    run(3, 1, 0, 4'h4, 0);
    cur_req = "R4";
    run(20, 1, 0, 4'hC, 0);

    // R6: snapshot reads leave the count growing
    cur_req = "R6";
    run(150, 1, 0, 4'hC, 0);

    // R7: turn on the interrupt enable
    cur_req = "R7";
    cyc(1, 1, 4'h0, 32'h0300_0003);
    run(10, 1, 0, 4'hC, 0);
    run(10, 0, 0, 4'h0, 0);

    // R5: single acknowledge read, then watch
    cur_req = "R5";
    cyc(1, 0, 4'h8, 0);
    run(70, 1, 0, 4'hC, 0);
    cyc(1, 0, 4'h8, 0);
    run(5, 1, 0, 4'h4, 0);

    // R10: period 0, acknowledge on every cycle
    cur_req = "R10";
    cyc(1, 1, 4'h0, 32'h0300_0000);
    run(64, 1, 0, 4'h8, 0);
    run(10, 1, 0, 4'hC, 0);

    // R11: writes to read-only offsets
    cur_req = "R11";
    run(3, 1, 1, 4'h4, 32'hFFFF_FFFF);
    run(3, 1, 1, 4'h8, 32'hFFFF_FFFF);
    run(3, 1, 1, 4'hC, 32'hFFFF_FFFF);
    run(3, 1, 0, 4'h0, 0);
    run(3, 1, 0, 4'h4, 0);
    cyc(1, 1, 4'h0, 32'h02AB_CDE5);
    run(3, 1, 0, 4'h0, 0);

    // R8: disable mid-interval, counter runs down to zero
    cur_req = "R8";
    cyc(1, 1, 4'h0, 32'h0100_0009);
    run(75, 1, 0, 4'hC, 0);
    cyc(1, 1, 4'h0, 32'h0000_0009);
    run(300, 1, 0, 4'hC, 0);

    // R9: 4096 unacknowledged periods wrap the count
    cur_req = "R9";
    cyc(1, 1, 4'h0, 32'h0100_0000);
    cyc(1, 0, 4'h8, 0);
    run(4096 * 16 + 40, 1, 0, 4'hC, 0);
    cyc(1, 0, 4'h8, 0);
    run(4, 1, 0, 4'hC, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule